// File: doc/BRIEF.md
# Sampling Pipeline Write/Read Sequencer

This block steers the addresses of a 64-cell analog sampling pipeline. During acquisition it moves a write pointer forward by one cell on each sample tick. A tick comes once every 500 ns, so a full pipeline covers 32 us of signal. On the read side it offers cell addresses to a digitizer one at a time. It waits for the digitizer's completion pulse before it moves on to the next cell.

There are two run modes.

- **Stop-then-read:** the block fills all 64 cells, stops writing, and then offers every cell in order.
- **Concurrent:** writing continues while the acquisition input is high. The read pointer trails the write pointer by a fixed latency. When acquisition ends, the block drains the cells that have not yet been read.

There are two digitize options.

- **Single-cell:** each read pairs cell n with the fixed reset level.
- **Correlated-difference:** each read pairs the neighbouring cells n-1 and n.

Top module: `pipe_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the following state after that edge: `wr_addr`=0, `rd_b`=0, `busy`=0, `done`=0, `overrun`=0, `rd_valid`=0 and `wr_en`=0.
- R2: A frame starts at a rising edge of `acq` sampled while idle. In stop-then-read mode (`mode_conc`=0), `wr_en` is high from the start of the frame. `wr_addr` starts at 0, advances by 1 on each cycle with `tick` high, and holds on cycles without `tick`.
- R3: After the 64th write in stop-then-read mode, `wr_en` drops and `rd_valid` rises. `rd_b` steps through cells 0..63 in order, advancing only on cycles where `dig_done` is high. When cell 63 has been acknowledged, `busy` falls and `done` rises.
- R4: With `opt_dcs`=0 latched at frame start, `rd_ref`=1 and `rd_a`=`rd_b`=n. The first value is the fixed reset level.
- R5: With `opt_dcs`=1 latched at frame start, `rd_ref`=0, `rd_a`=(n-1) mod 64 and `rd_b`=n. For cell 0, `rd_a`=63.
- R6: `pair_bad`=1 while cell 0 is offered in the correlated option when no write of cell 63 took place before the frame started and the read pointer has not wrapped in this frame. Otherwise `pair_bad`=0.
- R7: In concurrent mode (`mode_conc`=1) with `acq` high, `rd_valid` is high only when more than LAT written cells (default 4) are unread. The first read is therefore offered after LAT+1 ticks.
- R8: In concurrent mode, once `acq` falls, writing stops. Every unread cell is offered regardless of latency. One cycle after the last read, `busy` falls and `done` rises.
- R9: In concurrent mode, a tick that arrives while all 64 cells are unread and `dig_done` is low sets `overrun`, aborts the frame (`busy`=0, `done`=0) and leaves `wr_addr` unchanged. If `dig_done` arrives in the same cycle, there is no overrun.
- R10: The following inputs have no effect: `dig_done` while `rd_valid` is low, and a new rising edge of `acq` while `busy` is high.
- R11: A reset in the middle of a frame returns the block to idle with both pointers at 0. It also forgets any earlier full fill.
- R12: In concurrent mode, `wr_addr` and `rd_b` wrap modulo 64 and keep running across any number of wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Sample tick, one cycle per sample period |
| acq | input | 1 | Acquisition window: rising edge starts a frame; in concurrent mode its level keeps writing on |
| mode_conc | input | 1 | 0 = stop-then-read, 1 = concurrent (latched at start) |
| opt_dcs | input | 1 | 0 = single cell against reference, 1 = neighbouring pair (latched at start) |
| dig_done | input | 1 | Digitizer finished the offered pair |
| wr_addr | output | 6 | Cell written at the next tick while `wr_en` is high |
| wr_en | output | 1 | Writing active |
| rd_a | output | 6 | First cell of the pair (equals `rd_b` in single option) |
| rd_b | output | 6 | Cell n being digitized |
| rd_ref | output | 1 | First value is the fixed reset level |
| pair_bad | output | 1 | Offered pair has no valid predecessor |
| rd_valid | output | 1 | A read pair is offered |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | Last frame completed normally |
| overrun | output | 1 | Last concurrent frame aborted on overwrite |

## Verification
Stop-then-read frames are run in both digitize options, before and after a full fill has occurred. This tells apart the two address pairings and shows whether the predecessor flag is set correctly.

Concurrent frames are driven in three patterns:

- ticks alone, which locates the exact tick where latency is met;
- ticks and completions interleaved across more than one wrap, which tests the pointer arithmetic and clearing of the predecessor flag;
- completions alone after the window closes, which tests draining.

A final concurrent frame holds back completions until the pipeline is full. It then separates a tick that coincides with a completion, which must not overrun, from a bare tick, which must overrun.

// File: rtl/pipe_seq.sv
module pipe_seq #(
  parameter int DEPTH = 64,
  parameter int LAT   = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     tick,
  input  logic                     acq,
  input  logic                     mode_conc,
  input  logic                     opt_dcs,
  input  logic                     dig_done,
  output logic [$clog2(DEPTH)-1:0] wr_addr,
  output logic                     wr_en,
  output logic [$clog2(DEPTH)-1:0] rd_a,
  output logic [$clog2(DEPTH)-1:0] rd_b,
  output logic                     rd_ref,
  output logic                     pair_bad,
  output logic                     rd_valid,
  output logic                     busy,
  output logic                     done,
  output logic                     overrun
);
  localparam int AW = $clog2(DEPTH);
  localparam int OW = AW + 1;
  localparam logic [OW-1:0] LAT_C  = OW'(LAT);
  localparam logic [OW-1:0] FULL_C = OW'(DEPTH);
  localparam logic [AW-1:0] LAST   = AW'(DEPTH - 1);

  typedef enum logic [1:0] {S_IDLE, S_FILL, S_READ, S_CONC} st_t;

  st_t           st;
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [OW-1:0] occ;
  logic          acq_q, dcs_q, full_seen, prev_ok, done_q, ovr_q;

  logic start, rd_take, full, wr_do, ovr_hit;

  assign start    = (st == S_IDLE) && acq && !acq_q;
  assign wr_en    = (st == S_FILL) || ((st == S_CONC) && acq);
  assign rd_valid = (st == S_READ) ||
                    ((st == S_CONC) && (acq ? (occ > LAT_C) : (occ != '0)));
  assign rd_take  = rd_valid && dig_done;
  assign full     = (occ == FULL_C);
  assign ovr_hit  = (st == S_CONC) && acq && tick && full && !rd_take;
  assign wr_do    = wr_en && tick && !ovr_hit;

  assign wr_addr  = wr_ptr;
  assign rd_b     = rd_ptr;
  assign rd_a     = dcs_q ? rd_ptr - 1'b1 : rd_ptr;
  assign rd_ref   = !dcs_q;
  assign pair_bad = rd_valid && dcs_q && (rd_ptr == '0) && !prev_ok;
  assign busy     = (st != S_IDLE);
  assign done     = done_q;
  assign overrun  = ovr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ       <= '0;
      acq_q     <= 1'b0;
      dcs_q     <= 1'b0;
      full_seen <= 1'b0;
      prev_ok   <= 1'b0;
      done_q    <= 1'b0;
      ovr_q     <= 1'b0;
    end else begin
      acq_q <= acq;
      case (st)
        S_IDLE: if (start) begin
          st      <= mode_conc ? S_CONC : S_FILL;
          wr_ptr  <= '0;
          rd_ptr  <= '0;
          occ     <= '0;
          dcs_q   <= opt_dcs;
          prev_ok <= full_seen;
          done_q  <= 1'b0;
          ovr_q   <= 1'b0;
        end
        S_FILL: if (tick) begin
          wr_ptr <= wr_ptr + 1'b1;
          if (wr_ptr == LAST) begin
            full_seen <= 1'b1;
            st        <= S_READ;
          end
        end
        S_READ: if (dig_done) begin
          rd_ptr <= rd_ptr + 1'b1;
          if (rd_ptr == LAST) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end
        end
        S_CONC: begin
          if (ovr_hit) begin
            st    <= S_IDLE;
            ovr_q <= 1'b1;
          end else begin
            if (wr_do) begin
              wr_ptr <= wr_ptr + 1'b1;
              if (wr_ptr == LAST) full_seen <= 1'b1;
            end
            if (rd_take) begin
              rd_ptr <= rd_ptr + 1'b1;
              if (rd_ptr == LAST) prev_ok <= 1'b1;
            end
            occ <= occ + OW'(wr_do) - OW'(rd_take);
            if (!acq && occ == '0) begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pipe_seq_chk.sv
module pipe_seq_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst,
  input logic          tick,
  input logic          dig_done,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [AW-1:0] rd_a,
  input logic [AW-1:0] rd_b,
  input logic          rd_ref,
  input logic          pair_bad,
  input logic          rd_valid,
  input logic          busy,
  input logic          done,
  input logic          overrun
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (wr_addr == '0 && rd_b == '0 && !busy && !done && !overrun && !rd_valid));

  a_r2_wr_step: assert property (@(posedge clk) disable iff (rst)
    (wr_en && tick) |=> ((wr_addr == $past(wr_addr) + 1'b1) || overrun));

  a_r2_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !tick) |=> $stable(wr_addr));

  a_r3_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (busy && !(rd_valid && dig_done)) |=> $stable(rd_b));

  a_r4_single_pair: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ref) |-> (rd_a == rd_b));

  a_r5_dcs_pair: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ref) |-> (rd_a == rd_b - 1'b1));

  a_r6_bad_cell0: assert property (@(posedge clk) disable iff (rst)
    pair_bad |-> (rd_valid && !rd_ref && rd_b == '0));

  a_r9_overrun_abort: assert property (@(posedge clk) disable iff (rst)
    overrun |-> (!busy && !done));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rd_valid && !wr_en));
endmodule

bind pipe_seq pipe_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst(rst), .tick(tick), .dig_done(dig_done), .wr_en(wr_en),
  .wr_addr(wr_addr), .rd_a(rd_a), .rd_b(rd_b), .rd_ref(rd_ref),
  .pair_bad(pair_bad), .rd_valid(rd_valid), .busy(busy), .done(done),
  .overrun(overrun)
);

// File: tb/pipe_seq_test.sv
module pipe_seq_test;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, tick = 1'b0, acq = 1'b0, mode_conc = 1'b0, opt_dcs = 1'b0, dig_done = 1'b0;
  logic [5:0] wr_addr, rd_a, rd_b;
  logic wr_en, rd_ref, pair_bad, rd_valid, busy, done, overrun;

  int tests = 0, fails = 0;
  int w = 0, r = 0;
  bit seen63 = 0, prior = 0, dcs = 0;

  always #10 clk = ~clk;

  pipe_seq #(.DEPTH(64), .LAT(LAT)) uut (
    .clk(clk), .rst(rst), .tick(tick), .acq(acq), .mode_conc(mode_conc),
    .opt_dcs(opt_dcs), .dig_done(dig_done), .wr_addr(wr_addr), .wr_en(wr_en),
    .rd_a(rd_a), .rd_b(rd_b), .rd_ref(rd_ref), .pair_bad(pair_bad),
    .rd_valid(rd_valid), .busy(busy), .done(done), .overrun(overrun)
  );

  task automatic step;
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit tk, input bit dn);
    bit ev, dr, dw;
    ev = acq ? ((w - r) > LAT) : ((w - r) > 0);
    dr = dn && ev;
    dw = tk && acq && !((w - r) == 64 && !dr);
    tick = tk; dig_done = dn;
    step;
    tick = 0; dig_done = 0;
    if (dw) begin w++; if (w % 64 == 0) seen63 = 1; end
    if (dr) begin r++; if (r % 64 == 0) prior = 1; end
    ev = acq ? ((w - r) > LAT) : ((w - r) > 0);
    chk("R12 wr_addr", wr_addr, w % 64);
    chk("R7 rd_valid", rd_valid, ev);
    if (ev) begin
      chk("R12 rd_b", rd_b, r % 64);
      chk("R6 pair_bad", pair_bad, dcs && (r % 64 == 0) && !prior);
      chk("R5 rd_a", rd_a, dcs ? (r + 63) % 64 : r % 64);
    end
  endtask

  task automatic t_reset;
    step;
    chk("R1 wr_addr", wr_addr, 0);
    chk("R1 rd_b", rd_b, 0);
    chk("R1 busy", busy, 0);
    chk("R1 rd_valid", rd_valid, 0);
    chk("R1 wr_en", wr_en, 0);
    chk("R1 done", done, 0);
    chk("R1 overrun", overrun, 0);
    rst = 0;
    step;
  endtask

  task automatic t_conc;
    mode_conc = 1; opt_dcs = 1; dcs = 1;
    w = 0; r = 0; prior = seen63;
    acq = 1; step;
    chk("R7 busy", busy, 1);
    chk("R7 wr_en", wr_en, 1);
    cyc(0, 1);
    chk("R10 rd_b after stray done", rd_b, 0);
    for (int k = 1; k <= 6; k++) cyc(1, 0);
    for (int i = 0; i < 80; i++) begin
      if (i % 3 == 0) cyc(0, 0);
      cyc(1, 1);
    end
    acq = 0;
    while (w > r) cyc(0, 1);
    chk("R8 busy before end", busy, 1);
    step;
    chk("R8 busy", busy, 0);
    chk("R8 done", done, 1);
  endtask

  task automatic t_reset_mid;
    mode_conc = 1; opt_dcs = 1; dcs = 1;
    w = 0; r = 0; prior = seen63;
    acq = 1; step;
    for (int k = 0; k < 5; k++) cyc(1, 0);
    rst = 1; acq = 0; step; rst = 0;
    seen63 = 0;
    chk("R11 wr_addr", wr_addr, 0);
    chk("R11 rd_b", rd_b, 0);
    chk("R11 busy", busy, 0);
    chk("R11 rd_valid", rd_valid, 0);
    step;
  endtask

  task automatic t_fill(input bit d, input bit exp_prior);
    mode_conc = 0; opt_dcs = d; acq = 0; step;
    acq = 1; step;
    chk("R2 busy", busy, 1);
    chk("R2 wr_en", wr_en, 1);
    chk("R2 wr_addr start", wr_addr, 0);
    chk("R2 done cleared", done, 0);
    for (int i = 0; i < 64; i++) begin
      tick = 1; step; tick = 0;
      chk("R2 wr_addr step", wr_addr, (i + 1) % 64);
      if (i == 5) begin step; chk("R2 wr_addr hold", wr_addr, 6); end
      if (i == 10) begin
        dig_done = 1; step; dig_done = 0;
        chk("R10 done ignored in fill", wr_addr, 11);
        chk("R10 rd_valid in fill", rd_valid, 0);
      end
      if (i == 20) begin
        acq = 0; step; acq = 1; step;
        chk("R10 restart ignored", wr_addr, 21);
        chk("R10 busy kept", busy, 1);
      end
    end
    chk("R3 wr_en off", wr_en, 0);
    chk("R3 rd_valid on", rd_valid, 1);
    for (int n = 0; n < 64; n++) begin
      chk("R3 rd_b", rd_b, n);
      if (d) chk("R5 rd_a", rd_a, (n + 63) % 64);
      else   chk("R4 rd_a", rd_a, n);
      chk("R4 rd_ref", rd_ref, !d);
      chk("R6 pair_bad", pair_bad, d && n == 0 && !exp_prior);
      if (n == 7) begin step; chk("R3 rd_b hold", rd_b, 7); end
      dig_done = 1; step; dig_done = 0;
    end
    chk("R3 busy", busy, 0);
    chk("R3 done", done, 1);
    chk("R3 rd_valid", rd_valid, 0);
    acq = 0; step;
  endtask

  task automatic t_overrun;
    mode_conc = 1; opt_dcs = 0; acq = 0; step;
    acq = 1; step;
    for (int i = 0; i < 64; i++) begin
      tick = 1; step; tick = 0;
      chk("R9 no early overrun", overrun, 0);
    end
    chk("R9 wr_addr full", wr_addr, 0);
    chk("R9 rd_valid full", rd_valid, 1);
    tick = 1; dig_done = 1; step; tick = 0; dig_done = 0;
    chk("R9 tick with done", overrun, 0);
    chk("R9 wr_addr advanced", wr_addr, 1);
    chk("R9 rd_b advanced", rd_b, 1);
    tick = 1; step; tick = 0;
    chk("R9 overrun", overrun, 1);
    chk("R9 busy", busy, 0);
    chk("R9 done", done, 0);
    chk("R9 wr_addr kept", wr_addr, 1);
    acq = 0; step;
  endtask

  initial begin
    step;
    t_reset;
    t_conc;
    t_reset_mid;
    t_fill(1, 0);
    t_fill(0, 1);
    t_fill(1, 1);
    t_overrun;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule